// File: doc/BRIEF.md
# Segment Address Translator

This block turns a logical address into a physical one for a segmented memory scheme. A request carries a segment index and an offset within that segment, plus the kind of access and whether the requester runs in user mode. The index selects one entry of a small on-chip table. Each entry holds a base address, a length, a resident flag and three protection flags: writable, executable and supervisor-only. For a legal access the physical address is the base plus the offset. Otherwise the block returns one fault code.

The table is filled through a plain load port that writes one entry per cycle. Translation requests enter on a valid/ready stream. Results leave on a second valid/ready stream that holds one registered entry, so each result appears one cycle after its request is accepted. A request is accepted whenever the output slot is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low, the result stays frozen and no new request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and every table entry is non-resident.
- R2: A request names its segment with `req_seg` and its byte offset with `req_off`. The access kind `req_kind` is encoded as 0 = read, 1 = write, 2 = instruction fetch, 3 = read.
- R3: A cycle with `ld_en` high writes all fields of entry `ld_idx`. Requests accepted from the following cycle on see the new values. A request accepted in the same cycle sees the old entry.
- R4: A request to a non-resident segment returns fault code 1 (segment fault), whatever its offset, kind or mode.
- R5: A request to a resident segment whose offset is greater than or equal to the segment length returns fault code 2 (bounds error). A length of 0 rejects every offset.
- R6: A request that raises no fault returns fault code 0 and `rsp_paddr` = (base + offset) modulo 2^PA_W.
- R7: Fault code 3 (protection) is raised when a user-mode request (`req_user`=1) targets a supervisor-only segment, when a write targets a non-writable segment, or when a fetch targets a non-executable segment. Reads need no permission flag.
- R8: When several faults apply, the reported code follows the order segment fault, then bounds error, then protection. Every faulting result has `rsp_paddr` = 0.
- R9: Each accepted request produces exactly one result, visible the cycle after acceptance.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_paddr` and `rsp_fault` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one table entry |
| ld_idx | input | SEG_W | Entry to write |
| ld_base | input | PA_W | Segment base address |
| ld_size | input | OFF_W+1 | Segment length in bytes |
| ld_present | input | 1 | Segment is resident |
| ld_writable | input | 1 | Writes allowed |
| ld_exec | input | 1 | Instruction fetches allowed |
| ld_super | input | 1 | Supervisor-only segment |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_seg | input | SEG_W | Segment index |
| req_off | input | OFF_W | Offset within segment |
| req_kind | input | 2 | Access kind (see R2) |
| req_user | input | 1 | Requester is in user mode |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 segment, 2 bounds, 3 protection |

## Verification
The bench goes after the edges of the length compare. An offset of exactly length−1 must pass and an offset of exactly the length must fail. A design that used `<=` would let a byte past the end through, and one that treated a zero length as unlimited would accept offset 0. It drives requests that trip two or three faults at once, so a swapped priority shows up as the wrong code. It also uses a base near the top of the address space, where a design that dropped the wrap or mis-sized the adder would give a wrong address. A load and a request in the same cycle show whether the table write leaks into that translation. A stalled consumer shows whether the result register drops, overwrites or changes its content.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SEG   = 2'd1,
    FLT_BOUND = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RD2   = 2'd3
  } acc_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_N = 8,
  parameter int SEG_W = 3,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W:0]   wr_size,
  input  logic             wr_present,
  input  logic             wr_writable,
  input  logic             wr_exec,
  input  logic             wr_super,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W:0]   rd_size,
  output logic             rd_present,
  output logic             rd_writable,
  output logic             rd_exec,
  output logic             rd_super
);

  logic [PA_W-1:0] base_q [SEG_N];
  logic [OFF_W:0]  size_q [SEG_N];
  logic [SEG_N-1:0] pres_q, wrt_q, exe_q, sup_q;

  for (genvar g = 0; g < SEG_N; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[g] <= 1'b0;
        wrt_q[g]  <= 1'b0;
        exe_q[g]  <= 1'b0;
        sup_q[g]  <= 1'b0;
        base_q[g] <= '0;
        size_q[g] <= '0;
      end else if (hit) begin
        pres_q[g] <= wr_present;
        wrt_q[g]  <= wr_writable;
        exe_q[g]  <= wr_exec;
        sup_q[g]  <= wr_super;
        base_q[g] <= wr_base;
        size_q[g] <= wr_size;
      end
    end
  end

  always_comb begin
    rd_base     = '0;
    rd_size     = '0;
    rd_present  = 1'b0;
    rd_writable = 1'b0;
    rd_exec     = 1'b0;
    rd_super    = 1'b0;
    if (int'(rd_idx) < SEG_N) begin
      rd_base     = base_q[rd_idx];
      rd_size     = size_q[rd_idx];
      rd_present  = pres_q[rd_idx];
      rd_writable = wrt_q[rd_idx];
      rd_exec     = exe_q[rd_idx];
      rd_super    = sup_q[rd_idx];
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20
) (
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W:0]   size,
  input  logic             present,
  input  logic             writable,
  input  logic             exec,
  input  logic             super_only,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       kind,
  input  logic             user,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);

  logic in_range;
  logic prot_bad;
  logic [PA_W-1:0] off_ext;

  assign in_range = {1'b0, off} < size;
  assign off_ext  = PA_W'(off);

  always_comb begin
    prot_bad = user && super_only;
    unique case (kind)
      ACC_WRITE: prot_bad = prot_bad || !writable;
      ACC_FETCH: prot_bad = prot_bad || !exec;
      default:   ;
    endcase
  end

  always_comb begin
    paddr = '0;
    if (!present)       fault = FLT_SEG;
    else if (!in_range) fault = FLT_BOUND;
    else if (prot_bad)  fault = FLT_PROT;
    else begin
      fault = FLT_NONE;
      paddr = base + off_ext;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_N = 8,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  localparam int SEG_W = (SEG_N > 1) ? $clog2(SEG_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEG_W-1:0] ld_idx,
  input  logic [PA_W-1:0]  ld_base,
  input  logic [OFF_W:0]   ld_size,
  input  logic             ld_present,
  input  logic             ld_writable,
  input  logic             ld_exec,
  input  logic             ld_super,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);

  logic [PA_W-1:0] ent_base;
  logic [OFF_W:0]  ent_size;
  logic            ent_present, ent_writable, ent_exec, ent_super;
  fault_e          chk_fault;
  logic [PA_W-1:0] chk_paddr;
  logic            take;

  seg_table #(
    .SEG_N(SEG_N), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_en), .wr_idx(ld_idx), .wr_base(ld_base), .wr_size(ld_size),
    .wr_present(ld_present), .wr_writable(ld_writable),
    .wr_exec(ld_exec), .wr_super(ld_super),
    .rd_idx(req_seg), .rd_base(ent_base), .rd_size(ent_size),
    .rd_present(ent_present), .rd_writable(ent_writable),
    .rd_exec(ent_exec), .rd_super(ent_super)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .base(ent_base), .size(ent_size), .present(ent_present),
    .writable(ent_writable), .exec(ent_exec), .super_only(ent_super),
    .off(req_off), .kind(req_kind), .user(req_user),
    .fault(chk_fault), .paddr(chk_paddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= chk_paddr;
        rsp_fault <= chk_fault;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10: a stalled result stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9: an accepted request yields a result next cycle
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R4: a non-resident entry reports a segment fault
  p_seg_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ent_present |=> rsp_fault == FLT_SEG);

  // R8: faulting results carry no address
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_paddr == '0);

  // R5: an out-of-range resident request never reports success
  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ent_present && ({1'b0, req_off} >= ent_size)
    |=> rsp_fault == FLT_BOUND);

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

  localparam int SEG_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [SEG_W-1:0] ld_idx = '0;
  logic [19:0] ld_base = '0;
  logic [16:0] ld_size = '0;
  logic ld_present = 1'b0, ld_writable = 1'b0, ld_exec = 1'b0, ld_super = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [19:0] rsp_paddr;
  logic [1:0] rsp_fault;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_size(ld_size),
    .ld_present(ld_present), .ld_writable(ld_writable), .ld_exec(ld_exec),
    .ld_super(ld_super),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_kind(req_kind), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  // {seg[3], off[16], kind[2], user[1], fault[2], paddr[20]}
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {3'd0, 16'h0000, 2'd0, 1'b1, 2'd0, 20'h10000},  // R6 first byte
    {3'd0, 16'h00FF, 2'd1, 1'b1, 2'd0, 20'h100FF},  // R6 last byte, write ok
    {3'd0, 16'h0100, 2'd0, 1'b1, 2'd2, 20'h00000},  // R5 offset == size
    {3'd0, 16'h0010, 2'd2, 1'b1, 2'd3, 20'h00000},  // R7 fetch non-exec
    {3'd0, 16'h0100, 2'd2, 1'b1, 2'd2, 20'h00000},  // R8 bounds over prot
    {3'd1, 16'h01FF, 2'd2, 1'b1, 2'd0, 20'h000FF},  // R6 wrap
    {3'd1, 16'h0010, 2'd1, 1'b1, 2'd3, 20'h00000},  // R7 write read-only
    {3'd1, 16'h0010, 2'd0, 1'b1, 2'd0, 20'hFFF10},  // R6 read
    {3'd2, 16'hFFFF, 2'd1, 1'b0, 2'd0, 20'h103FF},  // R6 supervisor full length
    {3'd2, 16'h0000, 2'd0, 1'b1, 2'd3, 20'h00000},  // R7 user to supervisor
    {3'd3, 16'h0000, 2'd0, 1'b0, 2'd1, 20'h00000},  // R4 not resident
    {3'd3, 16'hFFFF, 2'd2, 1'b1, 2'd1, 20'h00000},  // R8 seg over all
    {3'd4, 16'h0000, 2'd0, 1'b0, 2'd2, 20'h00000},  // R5 zero length
    {3'd7, 16'h0000, 2'd0, 1'b0, 2'd1, 20'h00000},  // R4 never loaded
    {3'd2, 16'h8000, 2'd2, 1'b0, 2'd0, 20'h08400},  // R6 fetch ok
    {3'd0, 16'h0001, 2'd3, 1'b1, 2'd0, 20'h10001}   // R2 kind 3 is a read
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [SEG_W-1:0] idx, input logic [19:0] base,
                      input logic [16:0] size, input logic p, input logic w,
                      input logic x, input logic s);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_base = base; ld_size = size;
    ld_present = p; ld_writable = w; ld_exec = x; ld_super = s;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic xlate(input logic [SEG_W-1:0] seg, input logic [15:0] off,
                       input logic [1:0] kind, input logic user,
                       output logic [1:0] flt, output logic [19:0] pa);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1; req_seg = seg; req_off = off; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    flt = rsp_fault;
    pa  = rsp_paddr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] f;
    logic [19:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    xlate(3'd0, 16'h0, 2'd0, 1'b0, f, a);
    chk("R1", "fault empty table", 32'(f), 32'd1);

    // R3 table fill
    load(3'd0, 20'h10000, 17'h00100, 1, 1, 0, 0);
    load(3'd1, 20'hFFF00, 17'h00200, 1, 0, 1, 0);
    load(3'd2, 20'h00400, 17'h10000, 1, 1, 1, 1);
    load(3'd3, 20'h55555, 17'h00000, 0, 1, 1, 0);
    load(3'd4, 20'h12345, 17'h00000, 1, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      xlate(VEC[i][43:41], VEC[i][40:25], VEC[i][24:23], VEC[i][22], f, a);
      chk("R4-R8 vec", $sformatf("fault %0d", i), 32'(f), 32'(VEC[i][21:20]));
      chk("R6 vec", $sformatf("paddr %0d", i), 32'(a), 32'(VEC[i][19:0]));
    end

    // R3: same-cycle load uses old entry, next request sees new one
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'd5; ld_base = 20'h20000; ld_size = 17'h00010;
    ld_present = 1'b1; ld_writable = 1'b0; ld_exec = 1'b0; ld_super = 1'b0;
    req_valid = 1'b1; req_seg = 3'd5; req_off = 16'h4; req_kind = 2'd0; req_user = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0;
    chk("R3", "same-cycle fault", 32'(rsp_fault), 32'd1);
    xlate(3'd5, 16'h4, 2'd0, 1'b1, f, a);
    chk("R3", "after load fault", 32'(f), 32'd0);
    chk("R3", "after load paddr", 32'(a), 32'h20004);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 3'd0; req_off = 16'h5; req_kind = 2'd0; req_user = 1'b0;
    @(negedge clk);
    req_off = 16'h6;
    for (int k = 0; k < 3; k++) begin
      chk("R10", "stall valid", 32'(rsp_valid), 32'd1);
      chk("R10", "stall ready", 32'(req_ready), 32'd0);
      chk("R10", "stall paddr", 32'(rsp_paddr), 32'h10005);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "second result", 32'(rsp_paddr), 32'h10006);
    @(negedge clk);
    chk("R9", "drained", 32'(rsp_valid), 32'd0);

    // R1: reset clears the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    xlate(3'd0, 16'h0, 2'd0, 1'b0, f, a);
    chk("R1", "fault after reset", 32'(f), 32'd1);
    chk("R8", "paddr after reset", 32'(a), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule